// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is a small register file reached over a half-duplex serial bus with three wires: an active-low select, a serial clock and one shared data line. Every transaction begins with a seven-bit command, sent most significant bit first: a six-bit register address followed by a direction flag. A write then carries one pad clock and a data byte. A read leaves the line undriven for one clock so the bus can turn around, and then the block returns a byte. The shared line is presented as a separate input, output and output enable, which the pad ring combines.

Four registers are present. One is a scratch byte used to test the link. One is a read-only identity byte that holds a device number and a revision. One holds a three-bit resolution code. One is a control byte that holds a power-enable bit and a source-select bit. The source-select bit chooses whether the resolution code and standby state seen by the rest of the chip come from the registers or from strap pins. All bus inputs are synchronised into the system clock domain before they are decoded.

Top module: `tw3_spi_regs`

## Requirements
- R1: A frame begins with the address bits A5..A0, most significant first, sampled on rising serial clock edges. The seventh bit is the direction: 1 means read and 0 means write. All six address bits are decoded, so 0x3F does not alias 0x03.
- R2: On a write, the eighth clock is an ignored pad. Clocks 9 to 16 carry the data byte, most significant bit first. The byte is committed only after the sixteenth rising edge.
- R3: On a read, sdio_oe stays low through the eighth (turnaround) clock. The block then drives 8 data bits, most significant first, and changes sdio_out only after falling serial clock edges. sdio_oe is high only during these 8 bit times and drops after the falling edge that follows the sixteenth rising edge.
- R4: Address 0x00 is an 8-bit scratch register that reads back any value written to it.
- R5: Address 0x01 reads {CHIP_ID[3:0], CHIP_REV[3:0]}. Writes to it have no effect.
- R6: Address 0x02 stores the resolution code in bits 2:0. Bits 7:3 read as 0.
- R7: Address 0x03 stores the power enable in bit 0 (1 = running, 0 = standby) and the source select in bit 7. Bits 6:1 read as 0.
- R8: When bit 7 of 0x03 is 1, res_code follows register 0x02 and standby is the inverse of bit 0 of 0x03. When bit 7 is 0, res_code equals strap_res and standby equals the inverse of strap_pwr_en.
- R9: While rst_n is low (sampled on clk), the registers return to their defaults: scratch 0x00, resolution RES_DEFAULT, control 0x00. sdio_oe is also low.
- R10: Raising cs_n at any point ends the frame. A partial write is discarded, sdio_oe is released, and the next frame decodes normally.
- R11: Addresses 0x04 to 0x3F read as 0x00. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, sampled on clk |
| cs_n | input | 1 | Bus select, active low |
| sclk | input | 1 | Serial clock from the bus master |
| sdio_in | input | 1 | Data line as seen at the pad |
| sdio_out | output | 1 | Data value driven during read data |
| sdio_oe | output | 1 | Pad output enable for the data line |
| strap_res | input | 3 | Strap value for the resolution code |
| strap_pwr_en | input | 1 | Strap value for power enable |
| res_code | output | 3 | Resolution code in effect |
| standby | output | 1 | High when the panel logic should idle |

## Verification
Every bus input passes through SYNC_STAGES flops and one more edge-detect flop. A serial clock edge therefore takes effect three to four system clocks after the master makes it. sdio_out and sdio_oe settle at most four clocks after a falling edge. The bench holds each serial clock phase for eight system clocks and reads the data line at the end of the low phase, just before it raises the clock, which is the point where a real master samples. res_code and standby react to a write about four clocks after the sixteenth rising edge, and to strap changes combinationally. The bench reads these outputs only after a frame has closed and several more clocks have passed. Abort and release checks wait six clocks after cs_n rises.

// File: rtl/tw3_pkg.sv
package tw3_pkg;

    localparam int ADDR_W     = 6;
    localparam int DATA_W     = 8;
    localparam int RES_W      = 3;
    localparam int NIB_W      = 4;
    localparam int CMD_BITS   = ADDR_W + 1;
    localparam int DATA_START = CMD_BITS + 1;
    localparam int FRAME_BITS = DATA_START + DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int CTRL_PWR   = 0;
    localparam int CTRL_SEL   = 7;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [RES_W-1:0]  res_t;

    localparam cnt_t CNT_CMD   = cnt_t'(CMD_BITS);
    localparam cnt_t CNT_DATA  = cnt_t'(DATA_START);
    localparam cnt_t CNT_FULL  = cnt_t'(FRAME_BITS);
    localparam cnt_t CNT_LAST  = cnt_t'(FRAME_BITS - 1);

    localparam addr_t ADR_SCRATCH = addr_t'(0);
    localparam addr_t ADR_IDENT   = addr_t'(1);
    localparam addr_t ADR_RES     = addr_t'(2);
    localparam addr_t ADR_CTRL    = addr_t'(3);

    typedef struct packed {
        addr_t addr;
        logic  rd;
    } cmd_t;

    typedef struct packed {
        logic  we;
        addr_t addr;
        byte_t data;
    } wr_req_t;

    function automatic byte_t pack_ident(input logic [NIB_W-1:0] id,
                                         input logic [NIB_W-1:0] rev);
        return {id, rev};
    endfunction

endpackage

// File: rtl/tw3_sync.sv
module tw3_sync #(
    parameter int              WIDTH  = 3,
    parameter int              STAGES = 2,
    parameter logic [WIDTH-1:0] INIT  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= INIT;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tw3_frame.sv
module tw3_frame
    import tw3_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cs_act,
    input  logic    sclk_s,
    input  logic    sdi_s,
    input  byte_t   rd_data,
    output addr_t   rd_addr,
    output wr_req_t wr_req,
    output logic    sdo,
    output logic    oe
);
    logic  sclk_q;
    cnt_t  bit_cnt;
    cmd_t  cmd;
    byte_t wshift;
    byte_t tx;
    logic  rise, fall;

    assign rise    = cs_act &  sclk_s & ~sclk_q;
    assign fall    = cs_act & ~sclk_s &  sclk_q;
    assign rd_addr = cmd.addr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            bit_cnt <= '0;
            cmd     <= '0;
            wshift  <= '0;
            tx      <= '0;
            sdo     <= 1'b0;
            oe      <= 1'b0;
            wr_req  <= '0;
        end else begin
            sclk_q    <= sclk_s;
            wr_req.we <= 1'b0;
            if (!cs_act) begin
                bit_cnt <= '0;
                oe      <= 1'b0;
            end else begin
                if (rise && bit_cnt != CNT_FULL) begin
                    bit_cnt <= bit_cnt + cnt_t'(1);
                    if (bit_cnt < CNT_CMD)
                        cmd <= {cmd[CMD_BITS-2:0], sdi_s};
                    else if (bit_cnt >= CNT_DATA)
                        wshift <= {wshift[DATA_W-2:0], sdi_s};
                    if (bit_cnt == CNT_LAST && !cmd.rd) begin
                        wr_req.we   <= 1'b1;
                        wr_req.addr <= cmd.addr;
                        wr_req.data <= {wshift[DATA_W-2:0], sdi_s};
                    end
                end
                if (fall && cmd.rd) begin
                    if (bit_cnt == CNT_DATA) begin
                        sdo <= rd_data[DATA_W-1];
                        tx  <= {rd_data[DATA_W-2:0], 1'b0};
                        oe  <= 1'b1;
                    end else if (bit_cnt > CNT_DATA && bit_cnt < CNT_FULL) begin
                        sdo <= tx[DATA_W-1];
                        tx  <= {tx[DATA_W-2:0], 1'b0};
                    end else if (bit_cnt == CNT_FULL) begin
                        oe  <= 1'b0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/tw3_regs.sv
module tw3_regs
    import tw3_pkg::*;
#(
    parameter logic [NIB_W-1:0] CHIP_ID     = 4'h1,
    parameter logic [NIB_W-1:0] CHIP_REV    = 4'h0,
    parameter res_t             RES_DEFAULT = 3'd7
) (
    input  logic    clk,
    input  logic    rst_n,
    input  wr_req_t wr_req,
    input  addr_t   rd_addr,
    input  res_t    strap_res,
    input  logic    strap_pwr_en,
    output byte_t   rd_data,
    output res_t    res_code,
    output logic    standby
);
    byte_t scratch_q;
    res_t  res_q;
    logic  pwr_q;
    logic  sel_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scratch_q <= '0;
            res_q     <= RES_DEFAULT;
            pwr_q     <= 1'b0;
            sel_q     <= 1'b0;
        end else if (wr_req.we) begin
            case (wr_req.addr)
                ADR_SCRATCH: scratch_q <= wr_req.data;
                ADR_RES:     res_q     <= wr_req.data[RES_W-1:0];
                ADR_CTRL: begin
                    pwr_q <= wr_req.data[CTRL_PWR];
                    sel_q <= wr_req.data[CTRL_SEL];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADR_SCRATCH: rd_data = scratch_q;
            ADR_IDENT:   rd_data = pack_ident(CHIP_ID, CHIP_REV);
            ADR_RES:     rd_data[RES_W-1:0] = res_q;
            ADR_CTRL: begin
                rd_data[CTRL_PWR] = pwr_q;
                rd_data[CTRL_SEL] = sel_q;
            end
            default: rd_data = '0;
        endcase
    end

    assign res_code = sel_q ? res_q  : strap_res;
    assign standby  = sel_q ? ~pwr_q : ~strap_pwr_en;
endmodule

// File: rtl/tw3_spi_regs.sv
module tw3_spi_regs
    import tw3_pkg::*;
#(
    parameter logic [NIB_W-1:0] CHIP_ID     = 4'h1,
    parameter logic [NIB_W-1:0] CHIP_REV    = 4'h0,
    parameter res_t             RES_DEFAULT = 3'd7,
    parameter int               SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sclk,
    input  logic       sdio_in,
    output logic       sdio_out,
    output logic       sdio_oe,
    input  logic [2:0] strap_res,
    input  logic       strap_pwr_en,
    output logic [2:0] res_code,
    output logic       standby
);
    logic [2:0] pins_s;
    logic       cs_act, sclk_s, sdi_s;
    addr_t      rd_addr;
    byte_t      rd_data;
    wr_req_t    wr_req;

    tw3_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .INIT(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, sdio_in}), .q(pins_s)
    );

    assign cs_act = ~pins_s[2];
    assign sclk_s =  pins_s[1];
    assign sdi_s  =  pins_s[0];

    tw3_frame u_frame (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_s(sclk_s),
        .sdi_s(sdi_s), .rd_data(rd_data), .rd_addr(rd_addr),
        .wr_req(wr_req), .sdo(sdio_out), .oe(sdio_oe)
    );

    tw3_regs #(.CHIP_ID(CHIP_ID), .CHIP_REV(CHIP_REV), .RES_DEFAULT(RES_DEFAULT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_addr(rd_addr),
        .strap_res(strap_res), .strap_pwr_en(strap_pwr_en),
        .rd_data(rd_data), .res_code(res_code), .standby(standby)
    );
endmodule

// File: rtl/tw3_spi_regs_chk.sv
module tw3_spi_regs_chk
    import tw3_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sdio_oe,
    input logic       sdio_out,
    input logic       cs_act,
    input logic       sclk_s,
    input cnt_t       bit_cnt,
    input logic       wr_we,
    input addr_t      wr_addr,
    input byte_t      scratch,
    input logic [2:0] strap_res,
    input logic       strap_pwr_en,
    input logic [2:0] res_code,
    input logic       standby
);
    // R10: once the synchronised select is inactive, the line is released next cycle
    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !sdio_oe);

    // R3: the data value only moves in response to a falling serial clock
    p_out_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_s |=> $stable(sdio_out));

    // R3: driving starts only after the turnaround clock
    p_oe_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdio_oe) |-> (bit_cnt == CNT_DATA));

    // R4: scratch changes only through a write strobe to its address
    p_scratch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_we && wr_addr == ADR_SCRATCH) |=> $stable(scratch));

    // R8: with no write and steady straps, the exported controls stay put
    p_outputs_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_we |=> (!$stable(strap_res) || !$stable(strap_pwr_en) ||
                    ($stable(res_code) && $stable(standby))));

    // R9: after a reset cycle the straps are in control and the line is released
    p_reset_state_r9: assert property (@(posedge clk)
        !rst_n |=> (!sdio_oe && res_code == strap_res && standby == !strap_pwr_en));
endmodule

bind tw3_spi_regs tw3_spi_regs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sdio_oe(sdio_oe), .sdio_out(sdio_out),
    .cs_act(cs_act), .sclk_s(sclk_s), .bit_cnt(u_frame.bit_cnt),
    .wr_we(wr_req.we), .wr_addr(wr_req.addr), .scratch(u_regs.scratch_q),
    .strap_res(strap_res), .strap_pwr_en(strap_pwr_en),
    .res_code(res_code), .standby(standby)
);

// File: tb/tw3_spi_regs_test.sv
module tw3_spi_regs_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam logic [3:0] ID  = 4'hA;
    localparam logic [3:0] REV = 4'h3;
    localparam logic [2:0] RES_DEF = 3'd6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, sdio_in = 1'b0;
    logic sdio_out, sdio_oe;
    logic [2:0] strap_res = 3'd5;
    logic strap_pwr_en = 1'b1;
    logic [2:0] res_code;
    logic standby;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tw3_spi_regs #(.CHIP_ID(ID), .CHIP_REV(REV), .RES_DEFAULT(RES_DEF)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdio_in(sdio_in),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .strap_res(strap_res),
        .strap_pwr_en(strap_pwr_en), .res_code(res_code), .standby(standby)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_clk(input logic din, output logic dout, output logic oe_s);
        @(negedge clk);
        sclk = 1'b0;
        sdio_in = din;
        idle(HALF);
        dout = sdio_out;
        oe_s = sdio_oe;
        sclk = 1'b1;
        idle(HALF);
    endtask

    task automatic open_frame();
        @(negedge clk);
        sclk = 1'b0;
        cs_n = 1'b0;
        idle(HALF);
    endtask

    task automatic close_frame();
        @(negedge clk);
        sclk = 1'b0;
        idle(HALF);
        cs_n = 1'b1;
        idle(HALF);
    endtask

    task automatic send_cmd(input logic [5:0] a, input logic rd);
        logic d, o;
        for (int i = 5; i >= 0; i--) bit_clk(a[i], d, o);
        bit_clk(rd, d, o);
    endtask

    task automatic reg_write(input logic [5:0] a, input logic [7:0] v);
        logic d, o;
        logic any_oe;
        any_oe = 1'b0;
        open_frame();
        send_cmd(a, 1'b0);
        bit_clk(1'b1, d, o);
        any_oe |= o;
        for (int i = 7; i >= 0; i--) begin
            bit_clk(v[i], d, o);
            any_oe |= o;
        end
        close_frame();
        chk("R2 no drive during write", 32'(any_oe), 32'd0);
    endtask

    task automatic reg_read(input logic [5:0] a, output logic [7:0] v);
        logic d, o;
        logic all_oe;
        all_oe = 1'b1;
        open_frame();
        send_cmd(a, 1'b1);
        bit_clk(1'b0, d, o);
        chk("R3 turnaround undriven", 32'(o), 32'd0);
        for (int i = 7; i >= 0; i--) begin
            bit_clk(1'b0, d, o);
            v[i] = d;
            all_oe &= o;
        end
        chk("R3 drive through data bits", 32'(all_oe), 32'd1);
        @(negedge clk);
        sclk = 1'b0;
        idle(HALF);
        chk("R3 release after last bit", 32'(sdio_oe), 32'd0);
        cs_n = 1'b1;
        idle(HALF);
    endtask

    task automatic expect_reg(input string req, input logic [5:0] a, input logic [7:0] exp);
        logic [7:0] v;
        reg_read(a, v);
        chk(req, 32'(v), 32'(exp));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all requirements actual=timeout expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        logic d, o;
        logic [7:0] v;
        idle(5);
        // R9 reset state at the ports
        chk("R9 oe low in reset", 32'(sdio_oe), 32'd0);
        rst_n = 1'b1;
        idle(4);
        chk("R9 res_code from strap", 32'(res_code), 32'd5);
        chk("R9 standby from strap", 32'(standby), 32'd0);
        expect_reg("R9 scratch default", 6'h00, 8'h00);
        expect_reg("R9 R6 resolution default", 6'h02, {5'b0, RES_DEF});
        expect_reg("R9 R7 control default", 6'h03, 8'h00);

        // R5 identity, read-only
        expect_reg("R5 identity", 6'h01, {ID, REV});
        reg_write(6'h01, 8'hFF);
        expect_reg("R5 identity after write", 6'h01, {ID, REV});

        // R4 R2 R1 scratch sweep
        reg_write(6'h00, 8'h55);
        expect_reg("R4 scratch 55", 6'h00, 8'h55);
        for (int i = 0; i < 64; i++) begin
            logic [7:0] pat;
            pat = 8'((i * 37 + 5) & 255);
            reg_write(6'h00, pat);
            expect_reg("R4 R2 R1 scratch sweep", 6'h00, pat);
        end

        // R6 resolution codes; straps still in charge (R8)
        for (int c = 0; c < 8; c++) begin
            reg_write(6'h02, 8'hF8 | 8'(c));
            expect_reg("R6 resolution code", 6'h02, 8'(c));
            chk("R8 strap holds res_code", 32'(res_code), 32'd5);
        end

        // R7 control readback, R8 source selection
        reg_write(6'h03, 8'hFF);
        expect_reg("R7 control bits", 6'h03, 8'h81);
        chk("R8 register res_code", 32'(res_code), 32'd7);
        chk("R8 register standby off", 32'(standby), 32'd0);
        reg_write(6'h02, 8'h02);
        chk("R8 res_code follows write", 32'(res_code), 32'd2);
        reg_write(6'h03, 8'h80);
        chk("R8 standby from register", 32'(standby), 32'd1);
        strap_res = 3'd0;
        strap_pwr_en = 1'b0;
        idle(3);
        chk("R8 straps ignored res", 32'(res_code), 32'd2);
        chk("R8 straps ignored standby", 32'(standby), 32'd1);
        strap_pwr_en = 1'b1;
        idle(3);
        chk("R8 strap pwr ignored", 32'(standby), 32'd1);
        reg_write(6'h03, 8'h00);
        chk("R8 back to strap res", 32'(res_code), 32'd0);
        chk("R8 back to strap standby", 32'(standby), 32'd0);
        strap_pwr_en = 1'b0;
        idle(3);
        chk("R8 strap standby", 32'(standby), 32'd1);
        strap_pwr_en = 1'b1;
        strap_res = 3'd5;

        // R11 R1 unimplemented space, no aliasing
        reg_write(6'h00, 8'h3C);
        foreach (v[k]) begin end
        begin
            logic [5:0] holes [5];
            holes = '{6'h04, 6'h05, 6'h10, 6'h2A, 6'h3F};
            for (int k = 0; k < 5; k++) begin
                reg_write(holes[k], 8'hC3);
                expect_reg("R11 hole reads zero", holes[k], 8'h00);
            end
        end
        expect_reg("R11 R1 scratch untouched", 6'h00, 8'h3C);
        expect_reg("R11 R1 resolution untouched", 6'h02, 8'h02);
        expect_reg("R11 R1 control untouched by 3F", 6'h03, 8'h00);

        // R10 aborts
        reg_write(6'h00, 8'h11);
        open_frame();
        send_cmd(6'h00, 1'b0);
        bit_clk(1'b0, d, o);
        for (int i = 0; i < 5; i++) bit_clk(1'b1, d, o);
        close_frame();
        expect_reg("R10 partial write dropped", 6'h00, 8'h11);
        open_frame();
        send_cmd(6'h00, 1'b0);
        close_frame();
        expect_reg("R10 command-only frame", 6'h00, 8'h11);
        open_frame();
        send_cmd(6'h00, 1'b1);
        bit_clk(1'b0, d, o);
        for (int i = 0; i < 3; i++) bit_clk(1'b0, d, o);
        chk("R10 driving before abort", 32'(sdio_oe), 32'd1);
        cs_n = 1'b1;
        idle(6);
        chk("R10 released after abort", 32'(sdio_oe), 32'd0);
        idle(HALF);
        expect_reg("R10 next frame after abort", 6'h00, 8'h11);

        // R9 reset after configuration
        reg_write(6'h03, 8'h81);
        reg_write(6'h02, 8'h01);
        reg_write(6'h00, 8'h99);
        chk("R8 configured res", 32'(res_code), 32'd1);
        @(negedge clk);
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(4);
        chk("R9 straps after reset", 32'(res_code), 32'd5);
        chk("R9 standby after reset", 32'(standby), 32'd0);
        expect_reg("R9 scratch cleared", 6'h00, 8'h00);
        expect_reg("R9 control cleared", 6'h03, 8'h00);

        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule